// File: doc/BRIEF.md
# Audio Transmit FIFO Register Block

This block is the register and buffering front end of an audio transmit peripheral. Software writes 32-bit sample words to one of four data-port words. Each write pushes one word into a transmit FIFO. The FIFO holds interleaved stereo frames, two words per frame, left channel first. A downstream serializer drains the FIFO through a valid/ready stream and reads the configuration fields from dedicated pins.

The block offers four registers besides the data ports: a read-only version word, a configuration word, an interrupt mask and an interrupt status word. The two status bits are not latched events. They are recomputed from the FIFO occupancy every cycle:
- underrun is set while the FIFO is empty;
- level is set while the occupancy is below a trigger threshold. The threshold is the FIFO depth shifted right by the level field.

A single interrupt line is raised when interrupts are enabled and any status bit is also set in the mask.

The bus side is a plain request port. It carries no back-pressure: every request is taken in the cycle it is presented. Read data returns one cycle later with `rsp_valid`. The stream side follows valid/ready rules:
- `out_valid` never drops while the FIFO holds data and transmit stays enabled;
- a word leaves only in a cycle where both `out_valid` and `out_ready` are high;
- `out_data` is stable until that happens.

Top module: `audio_tx_regs`

## Requirements
- R1: After reset the configuration and mask registers read 0, the FIFO is empty (`fifo_empty`=1, `fifo_count`=0), every exported configuration pin is 0 and `irq` is 0.
- R2: Word offset 0 (byte 0x00) reads the constant VERSION parameter. Word offsets 4 to 7 (bytes 0x10 to 0x1C) read 0. Read data appears on `rsp_rdata` with `rsp_valid`=1 in the cycle after the read request.
- R3: The configuration register (word 1) uses these fields: bit 0 transmit enable, bit 1 interrupt enable, bit 2 left flag, bits 15:8 clock ratio, bits 21:16 sample resolution, bits 27:24 level, bits 31:28 channel setting. All other bits read 0, so the writable mask is 0xFF3FFF07. The transmit enable, left, ratio, resolution, level and channel fields are driven on the `cfg_*` pins.
- R4: A write to any of word offsets 4 to 7 pushes `req_wdata` into the FIFO, and the occupancy rises by one after that clock edge. A write to word 0 has no effect.
- R5: A push while the FIFO holds DEPTH words is dropped: the occupancy stays at DEPTH and the stored words come out unchanged.
- R6: `out_valid` is 1 exactly when transmit enable is 1 and the FIFO is non-empty. Words leave in push order, one per cycle in which `out_valid` and `out_ready` are both 1.
- R7: Interrupt status bit 0 (underrun) reads 1 exactly when the occupancy is 0.
- R8: Interrupt status bit 1 (level) reads 1 exactly when the occupancy is below DEPTH >> level field. For example, level 1 gives half the depth, and level 0 gives the full depth.
- R9: `irq` equals interrupt enable AND ((status AND mask) != 0).
- R10: A write to the status register (word 3) changes neither the status that is read back nor `irq`.
- R11: The mask register (word 2) stores bits 1:0, which line up with the status bits. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 3 | Word offset (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| out_valid | output | 1 | FIFO word available to the serializer |
| out_ready | input | 1 | Serializer takes the word |
| out_data | output | 32 | FIFO head word |
| fifo_empty | output | 1 | FIFO holds no words |
| fifo_count | output | CNT_W | FIFO occupancy |
| irq | output | 1 | Interrupt request |
| cfg_tx_en | output | 1 | Transmit enable field |
| cfg_left | output | 1 | Left flag field |
| cfg_ratio | output | 8 | Clock ratio field |
| cfg_res | output | 6 | Sample resolution field |
| cfg_level | output | 4 | Level (threshold shift) field |
| cfg_chan | output | 4 | Channel setting field |

## Verification
Every write takes effect at the clock edge that samples it. Because status and `irq` are decoded combinationally from the occupancy and register state, they are already correct for the new state before the next edge. Read data comes one edge after the request. The bench drives each request on a falling edge and samples at the next falling edge, which lies exactly one rising edge later. Stream pops are checked in the same way: head data is compared before the accepting edge, and occupancy after it.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  typedef struct packed {
    logic [3:0] chan;
    logic [3:0] level;
    logic [1:0] rsv1;
    logic [5:0] res;
    logic [7:0] ratio;
    logic [4:0] rsv0;
    logic       left;
    logic       int_en;
    logic       tx_en;
  } cfg_t;

  localparam logic [31:0] CFG_WMASK = 32'hFF3F_FF07;

  localparam logic [2:0] W_VERSION = 3'd0;
  localparam logic [2:0] W_CONFIG  = 3'd1;
  localparam logic [2:0] W_MASK    = 3'd2;
  localparam logic [2:0] W_STATUS  = 3'd3;

  localparam int ST_UNDERRUN = 0;
  localparam int ST_LEVEL    = 1;

endpackage

// File: rtl/atx_fifo.sv
module atx_fifo #(
  parameter int DEPTH = 1024,
  parameter int W     = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok;

  // Fullness is judged on the occupancy before any same-cycle pop.
  assign push_ok = push_req && (count != CNT_W'(DEPTH));
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop)     rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/atx_status.sv
module atx_status #(
  parameter int DEPTH = 1024,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic [CNT_W-1:0] count,
  input  logic [3:0]       level,
  input  logic             int_en,
  input  logic [1:0]       mask,
  output logic [1:0]       status,
  output logic             irq
);
  import audio_tx_pkg::*;

  logic [CNT_W-1:0] thr;

  assign thr                 = CNT_W'(DEPTH) >> level;
  assign status[ST_UNDERRUN] = (count == '0);
  assign status[ST_LEVEL]    = (count < thr);
  assign irq                 = int_en && |(status & mask);

endmodule

// File: rtl/atx_regs.sv
module atx_regs #(
  parameter logic [31:0] VERSION = 32'h0001_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [2:0]            req_word,
  input  logic [31:0]           req_wdata,
  input  logic [1:0]            status,
  output audio_tx_pkg::cfg_t    cfg,
  output logic [1:0]            mask,
  output logic                  push,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_rdata
);
  import audio_tx_pkg::*;

  logic wr, rd;
  assign wr   = req_valid && req_write;
  assign rd   = req_valid && !req_write;
  assign push = wr && req_word[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      mask      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (wr && req_word == W_CONFIG) cfg  <= cfg_t'(req_wdata & CFG_WMASK);
      if (wr && req_word == W_MASK)   mask <= req_wdata[1:0];
      rsp_valid <= rd;
      if (rd) begin
        case (req_word)
          W_VERSION: rsp_rdata <= VERSION;
          W_CONFIG:  rsp_rdata <= 32'(cfg);
          W_MASK:    rsp_rdata <= {30'd0, mask};
          W_STATUS:  rsp_rdata <= {30'd0, status};
          default:   rsp_rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/audio_tx_regs.sv
module audio_tx_regs #(
  parameter int          DEPTH   = 1024,
  parameter logic [31:0] VERSION = 32'h0001_0000,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [2:0]       req_word,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic             fifo_empty,
  output logic [CNT_W-1:0] fifo_count,
  output logic             irq,
  output logic             cfg_tx_en,
  output logic             cfg_left,
  output logic [7:0]       cfg_ratio,
  output logic [5:0]       cfg_res,
  output logic [3:0]       cfg_level,
  output logic [3:0]       cfg_chan
);
  import audio_tx_pkg::*;

  cfg_t       cfg;
  logic [1:0] mask_q;
  logic [1:0] status;
  logic       push, pop, int_en;

  atx_regs #(.VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_wdata(req_wdata),
    .status(status), .cfg(cfg), .mask(mask_q), .push(push),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  atx_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_req(push), .wdata(req_wdata),
    .pop(pop), .rdata(out_data), .count(fifo_count)
  );

  atx_status #(.DEPTH(DEPTH)) u_status (
    .count(fifo_count), .level(cfg.level), .int_en(int_en),
    .mask(mask_q), .status(status), .irq(irq)
  );

  assign int_en     = cfg.int_en;
  assign fifo_empty = (fifo_count == '0);
  assign out_valid  = cfg.tx_en && !fifo_empty;
  assign pop        = out_valid && out_ready;

  assign cfg_tx_en = cfg.tx_en;
  assign cfg_left  = cfg.left;
  assign cfg_ratio = cfg.ratio;
  assign cfg_res   = cfg.res;
  assign cfg_level = cfg.level;
  assign cfg_chan  = cfg.chan;

endmodule

// File: rtl/atx_chk.sv
module atx_chk #(
  parameter int DEPTH = 1024,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [2:0]       req_word,
  input logic             rsp_valid,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CNT_W-1:0] fifo_count,
  input logic             irq,
  input logic             int_en,
  input logic [1:0]       mask_q
);

  // R6
  nonempty_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (fifo_count != '0));

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_word[2] && fifo_count == CNT_W'(DEPTH)
     && !(out_valid && out_ready)) |=> (fifo_count == CNT_W'(DEPTH)));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq);

  // R7
  underrun_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && mask_q[0] && fifo_count == '0) |-> irq);

  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_word[2]) |=> (fifo_count <= $past(fifo_count)));

endmodule

bind audio_tx_regs atx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_word(req_word), .rsp_valid(rsp_valid), .out_valid(out_valid),
  .out_ready(out_ready), .fifo_count(fifo_count), .irq(irq),
  .int_en(int_en), .mask_q(mask_q)
);

// File: tb/sim_audio_tx_regs.sv
module sim_audio_tx_regs;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam logic [31:0] VER = 32'h0002_0103;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, out_ready = 1'b0;
  logic [2:0] req_word = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, out_valid, fifo_empty, irq;
  logic cfg_tx_en, cfg_left;
  logic [31:0] rsp_rdata, out_data;
  logic [CNT_W-1:0] fifo_count;
  logic [7:0] cfg_ratio;
  logic [5:0] cfg_res;
  logic [3:0] cfg_level, cfg_chan;

  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  audio_tx_regs #(.DEPTH(DEPTH), .VERSION(VER)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] w, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_word = w; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [2:0] w, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_word = w;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid", 32'(rsp_valid), 32'd1);
    d = rsp_rdata;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] cfgv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", 32'(fifo_count), 0);
    chk("R1 empty", 32'(fifo_empty), 1);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pins", {cfg_tx_en, cfg_left, cfg_ratio, cfg_res, cfg_level, cfg_chan}, 0);
    rd(3'd1, v); chk("R1 config", v, 0);
    rd(3'd2, v); chk("R1 mask", v, 0);
    rd(3'd3, v); chk("R7 status empty", v, 3);
    // R2 version and data-port reads
    rd(3'd0, v); chk("R2 version", v, VER);
    for (int w = 4; w < 8; w++) begin
      rd(3'(w), v); chk("R2 data port read", v, 0);
    end
    // R4 version write ignored
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R4 version kept", v, VER);
    chk("R4 no push", 32'(fifo_count), 0);
    // R3 config masking and pins
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R3 config mask", v, 32'hFF3F_FF07);
    wr(3'd1, 32'h5A2B_3C05);
    rd(3'd1, v); chk("R3 config pattern", v, 32'h5A2B_3C05 & 32'hFF3F_FF07);
    chk("R3 tx_en", 32'(cfg_tx_en), 1);
    chk("R3 left", 32'(cfg_left), 1);
    chk("R3 ratio", 32'(cfg_ratio), 32'h3C);
    chk("R3 res", 32'(cfg_res), 32'h2B);
    chk("R3 level", 32'(cfg_level), 32'hA);
    chk("R3 chan", 32'(cfg_chan), 32'h5);
    // R11 mask width
    wr(3'd2, 32'hFFFF_FFFD);
    rd(3'd2, v); chk("R11 mask", v, 1);
    // R9 int enable off: no irq even with status and mask set
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h3);
    chk("R9 irq gated", 32'(irq), 0);
    wr(3'd1, 32'h2);
    chk("R9 irq on", 32'(irq), 1);
    // R10 status write no effect
    wr(3'd3, 32'h0);
    rd(3'd3, v); chk("R10 status kept", v, 3);
    chk("R10 irq kept", 32'(irq), 1);

    // Sweep every level with every occupancy
    for (int lvl = 0; lvl < 16; lvl++) begin
      logic [1:0] m;
      m = (lvl % 2 == 1) ? 2'b11 : 2'b10;
      cfgv = 32'h2 | (32'(lvl) << 24);
      wr(3'd1, cfgv);
      wr(3'd2, 32'(m));
      for (int occ = 0; occ <= DEPTH; occ++) begin
        logic [1:0] es;
        es[0] = (occ == 0);
        es[1] = (occ < (DEPTH >> lvl));
        rd(3'd3, v);
        chk("R7 R8 status", v, 32'(es));
        chk("R9 irq", 32'(irq), 32'(|(es & m)));
        chk("R4 count", 32'(fifo_count), 32'(occ));
        if (occ < DEPTH) wr(3'(4 + occ % 4), 32'hA000_0000 | (32'(lvl) << 8) | 32'(occ));
      end
      // R5 push to full FIFO dropped
      wr(3'd5, 32'hDEAD_BEEF);
      chk("R5 full count", 32'(fifo_count), DEPTH);
      // R6 transmit disabled: no valid
      chk("R6 valid gated", 32'(out_valid), 0);
      wr(3'd1, cfgv | 32'h1);
      for (int k = 0; k < DEPTH; k++) begin
        @(negedge clk);
        chk("R6 valid", 32'(out_valid), 1);
        chk("R6 R5 order", out_data, 32'hA000_0000 | (32'(lvl) << 8) | 32'(k));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R6 count after pop", 32'(fifo_count), 32'(DEPTH - 1 - k));
      end
      chk("R6 empty valid", 32'(out_valid), 0);
      chk("R5 no extra word", 32'(fifo_empty), 1);
    end
    summary();
  end

endmodule